// File: doc/BRIEF.md
# Execute-Stage Arithmetic/Logic Unit with Condition Flags

This block is the arithmetic core of a small processor's execute stage. Each cycle it takes an opcode and two 32-bit operands and produces a 32-bit result with no register in the path. In the same cycle it works out four condition bits: zero, carry, negative and overflow. The condition bits are captured in a flag register on a clock edge only when the valid strobe is high. Later instructions can then test them.

The unit covers the following operations:
- add and subtract
- bitwise and, or and xor
- left shift, logical right shift and arithmetic right shift
- rotate left
- unsigned and signed 16x16 multiply

For shifts, carry receives the last bit pushed out of the word. Overflow flags any change of the sign bit. A shift distance of 32 or more behaves as a shift of exactly 32. The multiplies use only the low halves of the operands.

Top module: `exec_alu`

## Requirements
- R1: Opcode encoding is 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right, 7 arithmetic shift right, 8 rotate left, 9 unsigned multiply, 10 signed multiply, 11 to 15 pass B. Add returns A+B mod 2^32. Carry is the carry out of bit 31. Overflow is set when both operands share a sign that differs from the result's sign (so 0x7FFFFFFF+1 sets overflow and 0xFFFFFFFF+1 sets carry).
- R2: Subtract returns A-B. Carry is set when B > A unsigned (a borrow, so 0-1 sets it). Overflow is set when the operand signs differ and the result's sign differs from A (0x80000000-1 sets it).
- R3: And, or and xor return the bitwise result and clear carry and overflow.
- R4: Shift left moves A left by the distance with zero fill. Carry is the last bit shifted out. Overflow is set when result bit 31 differs from A bit 31.
- R5: Logical shift right moves A right with zero fill. Carry is the last bit shifted out. Overflow is set when result bit 31 differs from A bit 31 (0x80000000 by 1 sets it).
- R6: Arithmetic shift right fills with A bit 31. Carry is the last bit shifted out. Overflow is always clear.
- R7: The shift distance is B[5:0], and any value of 32 or more acts as 32. Shifting by 32 empties the word: left and logical right give 0, and arithmetic right gives all copies of the sign. A distance of 0 leaves A unchanged and clears carry; a B of 64 has distance 0.
- R8: Rotate left rotates A by B[4:0]. Carry is result bit 0 when that distance is nonzero and clear otherwise. Overflow is set when bit 31 changes.
- R9: Unsigned multiply returns A[15:0]*B[15:0] as an unsigned 32-bit product, so 0xFFFF*0xFFFF = 0xFFFE0001. Carry and overflow are clear.
- R10: Signed multiply treats A[15:0] and B[15:0] as two's-complement values and returns the 32-bit product: 0x8001*0x7FFF = 0xC000FFFF, 0x8001*0x8001 = 0x3FFF0001, 0x8000*0x8000 = 0x40000000. Carry and overflow are clear.
- R11: Flag bit positions are zero at bit 0, carry at bit 1, negative at bit 2 and overflow at bit 3. For every operation, zero is set when the result is all zeros and negative equals result bit 31.
- R12: The flag register loads on a rising clock edge only while valid is high. It keeps its value otherwise and is 0 after reset.
- R13: Opcodes 11 to 15 return B unchanged and clear carry and overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opcode | input | 4 | Operation select |
| opA | input | 32 | Operand A |
| opB | input | 32 | Operand B, shift distance or second factor |
| valid | input | 1 | Loads the flag register at the next edge |
| result | output | 32 | Combinational result |
| flags | output | 4 | Registered flags {overflow, negative, carry, zero} |

## Verification
The clocked properties assume that opcode, operands and valid stay steady around each rising edge. Under that assumption, the flags captured at an edge belong to the values the ports held just before it. The stimulus changes inputs only on falling edges. It raises valid for exactly one edge per vector and drops it between vectors. That makes every flag update traceable to a single vector, and lets the hold behaviour be checked with a deliberately mismatched operation.

// File: rtl/exec_alu_pkg.sv
package exec_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SHL  = 4'd5,
    OP_SHR  = 4'd6,
    OP_SAR  = 4'd7,
    OP_ROL  = 4'd8,
    OP_MULU = 4'd9,
    OP_MULS = 4'd10
  } aluOp_e;

  // flag bit positions inside the condition word
  localparam int FLAG_Z = 0;
  localparam int FLAG_C = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;

  typedef struct packed {
    logic       selArith;
    logic       subtract;
    logic       selLogic;
    logic [1:0] logicKind;   // 0 and, 1 or, 2 xor
    logic       selShift;
    logic [1:0] shiftKind;   // 0 left, 1 logical right, 2 arithmetic right, 3 rotate
    logic       selMul;
    logic       mulSigned;
    logic       selPass;
  } aluStrobes_t;
endpackage

// File: rtl/exec_alu_ctrl.sv
module exec_alu_ctrl
  import exec_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  opcode,
  input  logic        valid,
  input  logic [3:0]  nextFlags,
  output aluStrobes_t strobes,
  output logic [3:0]  flags
);
  always_comb begin
    strobes = '0;
    case (opcode)
      OP_ADD:  strobes.selArith = 1'b1;
      OP_SUB:  begin strobes.selArith = 1'b1; strobes.subtract = 1'b1; end
      OP_AND:  begin strobes.selLogic = 1'b1; strobes.logicKind = 2'd0; end
      OP_OR:   begin strobes.selLogic = 1'b1; strobes.logicKind = 2'd1; end
      OP_XOR:  begin strobes.selLogic = 1'b1; strobes.logicKind = 2'd2; end
      OP_SHL:  begin strobes.selShift = 1'b1; strobes.shiftKind = 2'd0; end
      OP_SHR:  begin strobes.selShift = 1'b1; strobes.shiftKind = 2'd1; end
      OP_SAR:  begin strobes.selShift = 1'b1; strobes.shiftKind = 2'd2; end
      OP_ROL:  begin strobes.selShift = 1'b1; strobes.shiftKind = 2'd3; end
      OP_MULU: strobes.selMul = 1'b1;
      OP_MULS: begin strobes.selMul = 1'b1; strobes.mulSigned = 1'b1; end
      default: strobes.selPass = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      flags <= '0;
    else if (valid) flags <= nextFlags;
  end

  // R1
  unit_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.selArith, strobes.selLogic, strobes.selShift,
              strobes.selMul, strobes.selPass}));

  // R12
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> $stable(flags));

  // R12
  flag_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> flags == $past(nextFlags));
endmodule

// File: rtl/exec_alu_datapath.sv
module exec_alu_datapath
  import exec_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  aluStrobes_t        strobes,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [WIDTH-1:0]   result,
  output logic [3:0]         nextFlags
);
  localparam int SH_W  = $clog2(WIDTH) + 1;
  localparam int ROT_W = SH_W - 1;
  localparam int MUL_W = WIDTH / 2;
  localparam int MSB   = WIDTH - 1;

  // add / subtract
  logic [WIDTH:0] sumExt;
  logic           arithV;
  always_comb begin
    sumExt = strobes.subtract ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    arithV = strobes.subtract ? ((a[MSB] != b[MSB]) && (sumExt[MSB] != a[MSB]))
                              : ((a[MSB] == b[MSB]) && (sumExt[MSB] != a[MSB]));
  end

  // logic
  logic [WIDTH-1:0] logicRes;
  always_comb begin
    case (strobes.logicKind)
      2'd0:    logicRes = a & b;
      2'd1:    logicRes = a | b;
      default: logicRes = a ^ b;
    endcase
  end

  // shifts: distance saturates at WIDTH
  logic [SH_W-1:0]   rawAmt, amt;
  logic [ROT_W-1:0]  rotAmt;
  logic [WIDTH:0]    shlExt, shrExt;
  logic signed [WIDTH:0] sarExt;
  logic [WIDTH-1:0]  rolRes, shiftRes;
  logic              shiftC;
  always_comb begin
    rawAmt = b[SH_W-1:0];
    amt    = (rawAmt > SH_W'(WIDTH)) ? SH_W'(WIDTH) : rawAmt;
    rotAmt = b[ROT_W-1:0];
    shlExt = {1'b0, a} << amt;
    shrExt = {a, 1'b0} >> amt;
    sarExt = $signed({a, 1'b0}) >>> amt;
    rolRes = (a << rotAmt) | (a >> (WIDTH - int'(rotAmt)));
    case (strobes.shiftKind)
      2'd0:    begin shiftRes = shlExt[WIDTH-1:0]; shiftC = shlExt[WIDTH]; end
      2'd1:    begin shiftRes = shrExt[WIDTH:1];   shiftC = shrExt[0];     end
      2'd2:    begin shiftRes = sarExt[WIDTH:1];   shiftC = sarExt[0];     end
      default: begin shiftRes = rolRes; shiftC = (rotAmt != '0) && rolRes[0]; end
    endcase
  end

  // multiply on the low halves
  logic [2*MUL_W-1:0]        mulU;
  logic signed [2*MUL_W-1:0] mulS;
  always_comb begin
    mulU = a[MUL_W-1:0] * b[MUL_W-1:0];
    mulS = $signed(a[MUL_W-1:0]) * $signed(b[MUL_W-1:0]);
  end

  // result and flag selection
  logic carry, ovf;
  always_comb begin
    result = b;
    carry  = 1'b0;
    ovf    = 1'b0;
    if (strobes.selArith) begin
      result = sumExt[WIDTH-1:0];
      carry  = sumExt[WIDTH];
      ovf    = arithV;
    end else if (strobes.selLogic) begin
      result = logicRes;
    end else if (strobes.selShift) begin
      result = shiftRes;
      carry  = shiftC;
      ovf    = (strobes.shiftKind != 2'd2) && (shiftRes[MSB] != a[MSB]);
    end else if (strobes.selMul) begin
      result = WIDTH'(strobes.mulSigned ? mulS : mulU);
    end
    nextFlags         = '0;
    nextFlags[FLAG_Z] = (result == '0);
    nextFlags[FLAG_C] = carry;
    nextFlags[FLAG_N] = result[MSB];
    nextFlags[FLAG_V] = ovf;
  end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       opcode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             valid,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flags
);
  aluStrobes_t strobes;
  logic [3:0]  nextFlags;

  exec_alu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opcode(opcode), .valid(valid),
    .nextFlags(nextFlags), .strobes(strobes), .flags(flags)
  );

  exec_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .strobes(strobes), .a(opA), .b(opB), .result(result), .nextFlags(nextFlags)
  );

  // R11
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> flags[FLAG_Z] == ($past(result) == '0));

  // R11
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> flags[FLAG_N] == $past(result[WIDTH-1]));

  // R3
  logic_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid && (opcode == OP_AND || opcode == OP_OR || opcode == OP_XOR)
    |=> !flags[FLAG_C] && !flags[FLAG_V]);

  // R6
  sar_no_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid && opcode == OP_SAR |=> !flags[FLAG_V]);

  // R7
  zero_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid && (opcode == OP_SHL || opcode == OP_SHR || opcode == OP_SAR)
    && opB[5:0] == 6'd0 |=> !flags[FLAG_C] && flags[FLAG_V] == 1'b0);
endmodule

// File: tb/tb_exec_alu.sv
module tb_exec_alu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opcode = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        valid = 1'b0;
  logic [31:0] result;
  logic [3:0]  flags;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  exec_alu dut (.clk(clk), .rstN(rstN), .opcode(opcode), .opA(opA), .opB(opB),
                .valid(valid), .result(result), .flags(flags));

  // flags word from requirement R11 layout
  function automatic logic [3:0] mkFlags(logic [31:0] r, logic c, logic v);
    return {v, r[31], c, r == 32'd0};
  endfunction

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, check result, let one edge load flags, check flags
  task automatic vec(string tag, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                     logic [31:0] expRes, logic expC, logic expV);
    @(negedge clk);
    opcode = op; opA = a; opB = b; valid = 1'b1;
    #1 check32({tag, " result"}, result, expRes);
    @(negedge clk);
    valid = 1'b0;
    check32({tag, " flags"}, {28'd0, flags}, {28'd0, mkFlags(expRes, expC, expV)});
  endtask

  task automatic testReset();
    check32("R12 reset flags", {28'd0, flags}, 32'd0);
  endtask

  task automatic testAdd();
    vec("R1 add plain", 4'd0, 32'd5, 32'd3, 32'd8, 1'b0, 1'b0);
    vec("R1 add ovf", 4'd0, 32'h7FFFFFFF, 32'd1, 32'h80000000, 1'b0, 1'b1);
    vec("R1 add carry", 4'd0, 32'hFFFFFFFF, 32'd1, 32'd0, 1'b1, 1'b0);
  endtask

  task automatic testSub();
    vec("R2 sub ovf", 4'd1, 32'h80000000, 32'd1, 32'h7FFFFFFF, 1'b0, 1'b1);
    vec("R2 sub borrow", 4'd1, 32'd0, 32'd1, 32'hFFFFFFFF, 1'b1, 1'b0);
    vec("R2 sub equal", 4'd1, 32'd7, 32'd7, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic testLogic();
    vec("R1 add sets carry", 4'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 1'b1, 1'b0);
    vec("R3 and", 4'd2, 32'hF0F01234, 32'h0FF0FFFF, 32'h00F01234, 1'b0, 1'b0);
    vec("R3 or", 4'd3, 32'h80000000, 32'd1, 32'h80000001, 1'b0, 1'b0);
    vec("R3 xor", 4'd4, 32'hDEADBEEF, 32'hDEADBEEF, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic testShl();
    vec("R4 shl sign up", 4'd5, 32'h40000000, 32'd1, 32'h80000000, 1'b0, 1'b1);
    vec("R4 shl out", 4'd5, 32'h80000000, 32'd1, 32'd0, 1'b1, 1'b1);
    vec("R4 shl 8", 4'd5, 32'h35, 32'd8, 32'h3500, 1'b0, 1'b0);
    vec("R7 shl 40", 4'd5, 32'd1, 32'd40, 32'd0, 1'b1, 1'b0);
    vec("R7 shl b64", 4'd5, 32'h12345678, 32'h40, 32'h12345678, 1'b0, 1'b0);
  endtask

  task automatic testShr();
    vec("R7 shr 32", 4'd6, 32'hFFFFFFFF, 32'd32, 32'd0, 1'b1, 1'b1);
    vec("R5 shr 1", 4'd6, 32'hFFFFFFFF, 32'd1, 32'h7FFFFFFF, 1'b1, 1'b1);
    vec("R5 shr sign", 4'd6, 32'h80000000, 32'd1, 32'h40000000, 1'b0, 1'b1);
    vec("R7 shr 0", 4'd6, 32'hFFFFFFFF, 32'd0, 32'hFFFFFFFF, 1'b0, 1'b0);
    vec("R5 shr 31", 4'd6, 32'h7FFFFFFF, 32'd31, 32'd0, 1'b1, 1'b0);
  endtask

  task automatic testSar();
    vec("R7 sar 32", 4'd7, 32'hFFFFFFFF, 32'd32, 32'hFFFFFFFF, 1'b1, 1'b0);
    vec("R7 sar 0", 4'd7, 32'hFFFFFFFF, 32'd0, 32'hFFFFFFFF, 1'b0, 1'b0);
    vec("R6 sar 4", 4'd7, 32'h80000000, 32'd4, 32'hF8000000, 1'b0, 1'b0);
    vec("R6 sar out", 4'd7, 32'h10, 32'd5, 32'd0, 1'b1, 1'b0);
    vec("R7 sar 63", 4'd7, 32'h40000000, 32'h3F, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic testRol();
    vec("R8 rol 31", 4'd8, 32'd1, 32'd31, 32'h80000000, 1'b0, 1'b1);
    vec("R8 rol wrap", 4'd8, 32'h80000000, 32'd1, 32'd1, 1'b1, 1'b1);
    vec("R8 rol 32", 4'd8, 32'h12345678, 32'd32, 32'h12345678, 1'b0, 1'b0);
  endtask

  task automatic testMul();
    vec("R9 mulu ffff", 4'd9, 32'hFFFF, 32'hFFFF, 32'hFFFE0001, 1'b0, 1'b0);
    vec("R9 mulu high junk", 4'd9, 32'hABCD0003, 32'h12340005, 32'd15, 1'b0, 1'b0);
    vec("R9 mulu 23171", 4'd9, 32'd23171, 32'd23171, 32'd536895241, 1'b0, 1'b0);
    vec("R10 muls mixed", 4'd10, 32'h8001, 32'h7FFF, 32'hC000FFFF, 1'b0, 1'b0);
    vec("R10 muls sq", 4'd10, 32'h8001, 32'h8001, 32'h3FFF0001, 1'b0, 1'b0);
    vec("R10 muls min", 4'd10, 32'h8000, 32'h8000, 32'h40000000, 1'b0, 1'b0);
    vec("R10 muls neg1", 4'd10, 32'h5555FFFF, 32'hAAAA0001, 32'hFFFFFFFF, 1'b0, 1'b0);
  endtask

  task automatic testPass();
    vec("R1 carry before pass", 4'd1, 32'd0, 32'd1, 32'hFFFFFFFF, 1'b1, 1'b0);
    vec("R13 pass zero", 4'd12, 32'd1, 32'd0, 32'd0, 1'b0, 1'b0);
    vec("R13 pass b", 4'd15, 32'd9, 32'h80000123, 32'h80000123, 1'b0, 1'b0);
  endtask

  task automatic testHold();
    vec("R12 load", 4'd0, 32'hFFFFFFFF, 32'd1, 32'd0, 1'b1, 1'b0);
    @(negedge clk);
    opcode = 4'd0; opA = 32'h7FFFFFFF; opB = 32'd1; valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check32("R12 hold flags", {28'd0, flags}, 32'h3);
    check32("R11 result live", result, 32'h80000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testAdd();
    testSub();
    testLogic();
    testShl();
    testShr();
    testSar();
    testRol();
    testMul();
    testPass();
    testHold();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule